// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a cycle-level, synthesizable model of a single-clock burst SRAM with a small parameterized array. Every control and data input is sampled on the rising clock edge. Two address strobes start accesses:

- The processor strobe always opens a read.
- The controller strobe opens a read or a write, according to the write enables seen on the same edge.

After an access has started, the advance input steps a 2-bit burst counter through the low two address bits. Read data comes straight from the array in the cycle after the address edge, so the read path has one register (the address) and no output register. A bidirectional bus is shown as separate `rdata`, `wdata` and `rdata_oe` signals.

A control state machine decides what kind of cycle was last registered. Its states are:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | Nothing is active. |
| `ST_READ` | A read data phase is active. |
| `ST_WRITE` | The last edge wrote the array. |
| `ST_SLEEP` | Snooze is held. |

Its transitions are:

| Transition | Condition |
|------------|-----------|
| to `ST_READ` | A selected strobe with no write, or an advance with no write. |
| to `ST_WRITE` | Any write edge. |
| stay in the current state | A suspend, meaning an active cycle with no strobe, no advance and no write. |
| to `ST_IDLE` | A strobe while deselected, or any edge while nothing is active. |
| to `ST_SLEEP` | Any edge with snooze high. |

From `ST_SLEEP`, decoding carries on as if the block were idle.

Top module: `sbsram_core`

## Requirements
- R1: An access starts only when `ce_n`=0, `ce2_n`=0 and `ce3`=1 on the strobe edge. A strobe that sees any other enable combination returns the block to idle, and `rdata_oe` is then 0.
- R2: With `burst_il`=0, after k advances the low two address bits equal (start + k) mod 4, wrapping after the fourth address. The upper address bits stay as loaded.
- R3: With `burst_il`=1, after k advances the low two address bits equal start XOR k.
- R4: With `gw_n`=1 and `bwe_n`=0, each `bw_n[i]`=0 writes only byte lane i (`wdata` bits 8i+7 down to 8i). Lanes whose `bw_n` bit is 1 keep their old contents.
- R5: `gw_n`=0 writes every lane, whatever `bwe_n` and `bw_n` are.
- R6: A selected processor strobe loads the address and starts a read, and the write enables on that edge are ignored. A later edge with write enables and `adv_n`=1 writes `wdata` to the loaded address.
- R7: A processor strobe has no effect while `ce_n`=1. A controller strobe on the same edge is decoded instead. With no controller strobe, an active read continues at its address.
- R8: A selected controller strobe with write enables writes `wdata` to `addr` on that same edge.
- R9: Read data for an address edge appears on `rdata` during the following cycle. `rdata_oe` is 1 only in read data phases and only while `oe_n`=0.
- R10: After a write edge, `rdata_oe` stays 0 through suspend cycles until a strobe or an advance starts a new cycle.
- R11: While `snooze`=1, `rdata_oe` drops without waiting for a clock, no edge writes the array, and no access continues once `snooze` is released.
- R12: After reset the block is idle with `rdata_oe`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address loaded by a strobe |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rdata_oe | output | 1 | Read bus drive enable |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2_n | input | 1 | Second chip enable, active low |
| ce3 | input | 1 | Third chip enable, active high |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Asynchronous idle request, active high |
| burst_il | input | 1 | Static burst order: 0 linear, 1 interleaved |

## Verification
The assertions check four things on every cycle:

- No edge loads an address while the chip is deselected.
- A processor strobe edge never writes, and snooze blocks every array write.
- A write edge leaves the bus undriven in the next cycle.
- The burst counter clears on a load, wraps after four steps, and leaves the upper address untouched.

Only the bench's scenarios can show that the right bytes reach the right word and that the two burst orders visit addresses in the required sequence. They also show that a delayed write after a processor strobe lands at the loaded address, and that data written while snooze was high never reaches the array. These checks compare data against a behavioural memory model over long runs.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } sb_state_e;
endpackage

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_il,
    input  logic              load,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);
    localparam int HI_W = ADDR_W - 2;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_step;

    function automatic logic [1:0] order_bits(input logic il, input logic [1:0] st,
                                              input logic [1:0] k);
        return il ? (st ^ k) : (st + k);
    endfunction

    assign cnt_step = cnt_q + 2'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (adv) begin
            cnt_q  <= cnt_step;
        end
    end

    always_comb begin
        cur_addr = {base_q[ADDR_W-1:2], order_bits(burst_il, base_q[1:0], cnt_q)};
        if (load)
            nxt_addr = addr_in;
        else if (adv)
            nxt_addr = {base_q[ADDR_W-1:2], order_bits(burst_il, base_q[1:0], cnt_step)};
        else
            nxt_addr = cur_addr;
    end

    // R2: the fourth advance wraps the count back to the first position
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && cnt_q == 2'd3) |=> (cnt_q == 2'd0));

    // R2: advancing never touches the upper address bits
    p_upper_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(base_q[ADDR_W-1:2]));

    // R8: a load restarts the burst at its first address
    p_load_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == 2'd0 && cur_addr == $past(addr_in)));

    logic unused_hi;
    assign unused_hi = (HI_W < 1);
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic [LANES-1:0]         lane_we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g])
                lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snooze,
    input  logic             ce_n,
    input  logic             ce2_n,
    input  logic             ce3,
    input  logic             ads_proc_n,
    input  logic             ads_ctrl_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             oe_n,
    output logic             load,
    output logic             adv,
    output logic [LANES-1:0] lane_we,
    output logic             rd_drive
);
    sb_state_e state_q, state_d;

    logic             sel;
    logic             active;
    logic             wr_req;
    logic             wr_go;
    logic [LANES-1:0] mask;

    assign sel    = !ce_n && !ce2_n && ce3;
    assign active = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign mask   = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : '0);
    assign wr_req = |mask;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next-state and cycle decode
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        adv     = 1'b0;
        wr_go   = 1'b0;
        if (snooze) begin
            state_d = ST_SLEEP;
        end else if (!ads_proc_n && !ce_n) begin
            if (sel) begin
                load    = 1'b1;
                state_d = ST_READ;
            end else begin
                state_d = ST_IDLE;
            end
        end else if (!ads_ctrl_n) begin
            if (sel) begin
                load    = 1'b1;
                wr_go   = wr_req;
                state_d = wr_req ? ST_WRITE : ST_READ;
            end else begin
                state_d = ST_IDLE;
            end
        end else if (active) begin
            adv   = !adv_n;
            wr_go = wr_req;
            if (wr_req)
                state_d = ST_WRITE;
            else if (!adv_n)
                state_d = ST_READ;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // outputs
    always_comb begin
        lane_we = wr_go ? mask : '0;
        unique case (state_q)
            ST_READ:  rd_drive = !oe_n && !snooze;
            ST_IDLE,
            ST_WRITE,
            ST_SLEEP: rd_drive = 1'b0;
            default:  rd_drive = 1'b0;
        endcase
    end

    // R12: reset leaves the machine idle on the first edge
    p_reset_idle_r12: assert property (@(posedge clk)
        !rst_n |-> (state_q == ST_IDLE));

    // R10: a write edge is never followed by a read phase
    p_write_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |=> (state_q != ST_READ));
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe,
    input  logic                    ce_n,
    input  logic                    ce2_n,
    input  logic                    ce3,
    input  logic                    ads_proc_n,
    input  logic                    ads_ctrl_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    snooze,
    input  logic                    burst_il
);
    logic              load, adv;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] cur_addr, nxt_addr;

    sbsram_ctrl #(.LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .snooze(snooze),
        .ce_n(ce_n), .ce2_n(ce2_n), .ce3(ce3),
        .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .load(load), .adv(adv), .lane_we(lane_we), .rd_drive(rdata_oe)
    );

    sbsram_burst_ctr #(.ADDR_W(ADDR_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .burst_il(burst_il),
        .load(load), .adv(adv), .addr_in(addr),
        .cur_addr(cur_addr), .nxt_addr(nxt_addr)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .lane_we(lane_we), .waddr(nxt_addr), .wdata(wdata),
        .raddr(cur_addr), .rdata(rdata)
    );

    // R1: no address is loaded unless all three enables select the chip
    p_sel_on_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!ce_n && !ce2_n && ce3));

    // R6: a processor strobe edge never writes the array
    p_proc_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_proc_n && !ce_n) |-> (lane_we == '0));

    // R11: snooze blocks every array write
    p_snooze_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |-> (lane_we == '0));

    // R9: the bus is driven only while the output enable is low
    p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (!oe_n && !snooze));

    // R10: the cycle after a write edge leaves the bus undriven
    p_write_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |=> !rdata_oe);
endmodule

// File: tb/sbsram_core_bench.sv
module sbsram_core_bench;
    localparam int AW = 6;
    localparam int NL = 2;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic rdata_oe;
    logic ce_n = 1'b0, ce2_n = 1'b0, ce3 = 1'b1;
    logic ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
    logic gw_n = 1'b1, bwe_n = 1'b1;
    logic [NL-1:0] bw_n = '1;
    logic oe_n = 1'b0, snooze = 1'b0, burst_il = 1'b0;

    always #2 clk = ~clk;

    sbsram_core u_sbsram_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rdata_oe(rdata_oe), .ce_n(ce_n), .ce2_n(ce2_n), .ce3(ce3),
        .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .snooze(snooze), .burst_il(burst_il)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R12";

    // reference model: 0 idle, 1 read, 2 write, 3 sleep
    int ms = 0;
    int mbase = 0;
    int mcnt = 0;
    logic [15:0] mm [DEPTH];

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
        end
    endtask

    function automatic int eff_addr();
        int lo;
        if (burst_il) lo = (mbase % 4) ^ mcnt;
        else          lo = ((mbase % 4) + mcnt) % 4;
        return (mbase / 4) * 4 + lo;
    endfunction

    task automatic model_write(input int a, input int msk);
        for (int i = 0; i < NL; i++)
            if ((msk >> i) & 1) mm[a][i*8 +: 8] = wdata[i*8 +: 8];
    endtask

    task automatic model_edge();
        bit sel = !ce_n && !ce2_n && ce3;
        bit act = (ms == 1) || (ms == 2);
        int msk = 0;
        if (!gw_n) msk = 3;
        else if (!bwe_n) msk = int'(~bw_n) & 3;
        if (snooze) ms = 3;
        else if (!ads_proc_n && !ce_n) begin
            if (sel) begin mbase = int'(addr); mcnt = 0; ms = 1; end
            else ms = 0;
        end else if (!ads_ctrl_n) begin
            if (sel) begin
                mbase = int'(addr); mcnt = 0;
                if (msk != 0) begin model_write(mbase, msk); ms = 2; end
                else ms = 1;
            end else ms = 0;
        end else if (act) begin
            if (!adv_n) mcnt = (mcnt + 1) % 4;
            if (msk != 0) begin model_write(eff_addr(), msk); ms = 2; end
            else if (!adv_n) ms = 1;
        end else ms = 0;
    endtask

    task automatic compare();
        bit exp_oe = (ms == 1) && !oe_n && !snooze;
        chk(phase, {31'd0, rdata_oe}, {31'd0, exp_oe});
        if (exp_oe) chk(phase, {16'd0, rdata}, {16'd0, mm[eff_addr()]});
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic rest();
        ads_proc_n = 1; ads_ctrl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1;
        bw_n = '1; ce_n = 0; ce2_n = 0; ce3 = 1; wdata = '0;
    endtask

    task automatic ctrl_wr(input int a, input logic [15:0] d);
        rest(); ads_ctrl_n = 0; addr = AW'(a); wdata = d; gw_n = 0; step();
    endtask

    task automatic ctrl_rd(input int a);
        rest(); ads_ctrl_n = 0; addr = AW'(a); step();
    endtask

    task automatic adv_rd();
        rest(); adv_n = 0; step();
    endtask

    task automatic hold();
        rest(); step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", {31'd0, rdata_oe}, 32'd0);
        rst_n = 1;
        hold();

        // R8/R5: fill with controller-strobe global writes
        phase = "R8";
        for (int i = 0; i < DEPTH; i++) ctrl_wr(i, 16'(i * 16'h0101) ^ 16'h5A3C);

        // R2: linear burst from low bits 2
        phase = "R2"; burst_il = 0;
        ctrl_rd(6);
        for (int k = 0; k < 5; k++) adv_rd();
        // R3: interleaved burst from low bits 1
        phase = "R3"; burst_il = 1;
        ctrl_rd(9);
        for (int k = 0; k < 5; k++) adv_rd();
        ctrl_rd(14);
        for (int k = 0; k < 3; k++) adv_rd();
        burst_il = 0;

        // R4: byte lanes
        phase = "R4";
        rest(); ads_ctrl_n = 0; addr = 6'd20; wdata = 16'hBEEF; bwe_n = 0; bw_n = 2'b10; step();
        ctrl_rd(20);
        rest(); ads_ctrl_n = 0; addr = 6'd21; wdata = 16'hC0DE; bwe_n = 0; bw_n = 2'b01; step();
        ctrl_rd(21);
        rest(); ads_ctrl_n = 0; addr = 6'd22; wdata = 16'h1111; bwe_n = 1; bw_n = 2'b00; step();
        ctrl_rd(22);

        // R5: global write overrides byte selects
        phase = "R5";
        rest(); ads_ctrl_n = 0; addr = 6'd23; wdata = 16'h7E57; gw_n = 0; bwe_n = 1; bw_n = 2'b11; step();
        ctrl_rd(23);

        // R6: processor strobe ignores enables on its edge, write follows
        phase = "R6";
        rest(); ads_proc_n = 0; addr = 6'd30; wdata = 16'hDEAD; gw_n = 0; step();
        rest(); wdata = 16'hF00D; gw_n = 0; step();
        ctrl_rd(30);
        rest(); ads_proc_n = 0; addr = 6'd31; step();
        rest(); wdata = 16'hAB12; bwe_n = 0; bw_n = 2'b01; step();
        rest(); ads_proc_n = 0; addr = 6'd31; step();

        // R7: processor strobe ignored while ce_n high
        phase = "R7";
        ctrl_rd(40);
        rest(); ads_proc_n = 0; ce_n = 1; addr = 6'd44; step();
        hold();
        rest(); ads_proc_n = 0; ce_n = 1; ads_ctrl_n = 0; ce2_n = 0; addr = 6'd45; step();
        rest(); ads_ctrl_n = 0; ce_n = 0; ce3 = 0; addr = 6'd46; step();
        rest(); ads_proc_n = 0; ce_n = 1; addr = 6'd47; step();

        // R1: deselection by each enable
        phase = "R1";
        ctrl_rd(1);
        rest(); ads_ctrl_n = 0; ce2_n = 1; addr = 6'd2; step();
        rest(); ads_ctrl_n = 0; ce_n = 1; addr = 6'd3; step();
        rest(); ads_proc_n = 0; ce3 = 0; addr = 6'd4; step();
        ctrl_rd(5);

        // R10: bus idle after write until advance
        phase = "R10";
        ctrl_wr(50, 16'h4242);
        hold(); hold();
        adv_rd();
        hold();

        // R9: output enable gating
        phase = "R9";
        ctrl_rd(12);
        oe_n = 1; hold(); adv_rd();
        oe_n = 0; hold();

        // R11: snooze
        phase = "R11";
        ctrl_rd(33);
        snooze = 1; #1;
        chk("R11", {31'd0, rdata_oe}, 32'd0);
        ctrl_wr(33, 16'h0BAD);
        adv_rd();
        snooze = 0;
        hold();
        adv_rd();
        ctrl_rd(33);
        hold();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule